// File: doc/BRIEF.md
# UART Interrupt Status and Control Register File

This block holds the interrupt bookkeeping and line configuration of a high-speed UART. The receive and transmit paths send one-cycle event pulses. Each pulse sets a bit in a latched status register. Software clears each status bit on its own by writing a one to it.

A second register packs the line configuration into one word. It holds the transmit and receive FIFO thresholds, the receive inactivity timeout code, the hardware flow-control enables, polarities and RTS threshold, the sampling offset and a forced break. It also holds three interrupt enables, one per group of status sources. The block masks the latched status with these enables and combines the result into a single interrupt request.

Both registers sit on a plain 32-bit bus with a single-cycle write strobe. Reads are combinational. The FIFOs and the serializer lie outside this block. They consume the decoded configuration fields and produce the event pulses.

Top module: `uart_irq_regs`

## Requirements
- R1: After reset the status register reads 0, the control register reads 0x00002800 (sampling offset 20, every other field 0), and irq_o is low.
- R2: A pulse on evt_i[n] sets status bit n at the next clock edge. The bit then stays set until software clears it. Status bit meanings: 0 transmit request, 1 receive trigger, 2 receive timeout, 3 framing error, 4 break received, 5 receive overrun, 6 transmit-interrupt-set indicator.
- R3: A bus write to offset 0x08 clears every status bit whose data bit is one. Status bits written with zero keep their value.
- R4: When an event pulse and a write-one clear hit the same status bit in the same cycle, the bit is set after that edge.
- R5: A bus write to offset 0x0C stores data bits 21:0 in the control register. Reading offset 0x0C returns them, with bits 31:22 reading as zero.
- R6: The control fields sit at fixed bit positions and drive their outputs directly:
  - tx_level_o: bits 1:0 (transmit threshold: empty, 4, 8 or 16 bytes)
  - rx_level_o: bits 4:2 (receive threshold)
  - transmit interrupt enable: bit 5
  - receive interrupt enable: bit 6
  - error interrupt enable: bit 7
  - break_o: bit 8
  - sample_ofs_o: bits 13:9
  - cts_en_o: bit 14
  - cts_inv_o: bit 15
  - rx_tmo_o: bits 17:16
  - rts_en_o: bit 18
  - rts_level_o: bits 20:19 (RTS threshold: 8, 16, 32 or 48)
  - rts_inv_o: bit 21
- R7: irq_o is high exactly when at least one of these holds:
  - status bit 0 is set and the transmit enable is set;
  - status bit 1 or 2 is set and the receive enable is set;
  - status bit 3, 4 or 5 is set and the error enable is set.

  Status bit 6 never raises irq_o.
- R8: A write to the control offset leaves the status register unchanged, and a write to the status offset leaves the control register unchanged. Writes to any other offset change neither register. Reads of any other offset return 0.
- R9: Status reads return zero in bits 31:7, whatever was written or pulsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 8 | Byte offset of the register access |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i (combinational) |
| evt_i | input | 7 | Event pulses, one per status bit |
| tx_level_o | output | 2 | Transmit FIFO threshold code |
| rx_level_o | output | 3 | Receive FIFO threshold code |
| break_o | output | 1 | Force break on transmit line |
| sample_ofs_o | output | 5 | Receive sampling offset |
| cts_en_o | output | 1 | Hardware CTS flow control enable |
| cts_inv_o | output | 1 | CTS polarity invert |
| rx_tmo_o | output | 2 | Receive inactivity timeout code |
| rts_en_o | output | 1 | Hardware RTS flow control enable |
| rts_level_o | output | 2 | RTS assertion threshold code |
| rts_inv_o | output | 1 | RTS polarity invert |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Two functions can land in the same cycle on one status bit: a source pulse setting the bit and a software write-one clearing it. The bench provokes this by raising evt_i on a bit in the same cycle as a status write that has a one in that bit. It expects the bit still set and irq_o still high afterwards. A second collision case mixes functions on different bits: one bit is cleared while another is pulsed in the same write cycle. The bench expects both results to appear together.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int unsigned STAT_W = 7;
  localparam int unsigned CTRL_W = 22;

  localparam int unsigned ST_TX_REQ  = 0;
  localparam int unsigned ST_RX_TRIG = 1;
  localparam int unsigned ST_RX_TMO  = 2;
  localparam int unsigned ST_FRAME   = 3;
  localparam int unsigned ST_BREAK   = 4;
  localparam int unsigned ST_OVERRUN = 5;
  localparam int unsigned ST_TX_SET  = 6;

  // layout is fixed: consumers decode by bit position
  typedef struct packed {
    logic       rts_inv;   // 21
    logic [1:0] rts_lvl;   // 20:19
    logic       rts_en;    // 18
    logic [1:0] tmo;       // 17:16
    logic       cts_inv;   // 15
    logic       cts_en;    // 14
    logic [4:0] ofs;       // 13:9
    logic       brk;       // 8
    logic       err_ie;    // 7
    logic       rx_ie;     // 6
    logic       tx_ie;     // 5
    logic [2:0] rx_thr;    // 4:2
    logic [1:0] tx_thr;    // 1:0
  } ctrl_t;
endpackage

// File: rtl/uart_irq_status.sv
module uart_irq_status
  import uart_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [STAT_W-1:0] wdata_i,
  input  logic [STAT_W-1:0] evt_i,
  output logic [STAT_W-1:0] status_o
);
  logic [STAT_W-1:0] clr;
  logic [STAT_W-1:0] status_q;

  assign clr = we_i ? wdata_i : '0;

  for (genvar i = 0; i < STAT_W; i++) begin : g_bit
    // set has priority over clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        status_q[i] <= 1'b0;
      else if (evt_i[i])  status_q[i] <= 1'b1;
      else if (clr[i])    status_q[i] <= 1'b0;
    end

    assert_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_i[i] |=> status_q[i]);
    assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (status_q[i] && !clr[i]) |=> status_q[i]);
    assert_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr[i] && !evt_i[i]) |=> !status_q[i]);
    assert_keep_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!clr[i] && !evt_i[i]) |=> $stable(status_q[i]));
    assert_setwins_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr[i] && evt_i[i]) |=> status_q[i]);
  end

  assign status_o = status_q;
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int unsigned OFS_RESET = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CTRL_W-1:0] wdata_i,
  output ctrl_t             ctrl_o
);
  localparam ctrl_t CTRL_RST = '{ofs: 5'(OFS_RESET), default: '0};

  ctrl_t ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ctrl_q <= CTRL_RST;
    else if (we_i) ctrl_q <= ctrl_t'(wdata_i);
  end

  assert_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (ctrl_q == $past(wdata_i)));
  assert_keep_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(ctrl_q));

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/uart_irq_combine.sv
module uart_irq_combine
  import uart_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [STAT_W-1:0] status_i,
  input  logic              tx_ie_i,
  input  logic              rx_ie_i,
  input  logic              err_ie_i,
  output logic              irq_o
);
  logic [STAT_W-1:0] mask;

  always_comb begin
    mask             = '0;
    mask[ST_TX_REQ]  = tx_ie_i;
    mask[ST_RX_TRIG] = rx_ie_i;
    mask[ST_RX_TMO]  = rx_ie_i;
    mask[ST_FRAME]   = err_ie_i;
    mask[ST_BREAK]   = err_ie_i;
    mask[ST_OVERRUN] = err_ie_i;
  end

  assign irq_o = |(status_i & mask);

  assert_src_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (status_i[ST_OVERRUN:ST_TX_REQ] != '0));
  assert_noen_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_ie_i && !rx_ie_i && !err_ie_i) |-> !irq_o);
  assert_txset_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($onehot0(status_i) && status_i[ST_TX_SET]) |-> !irq_o);
endmodule

// File: rtl/uart_irq_regs.sv
module uart_irq_regs
  import uart_irq_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned STAT_OFS  = 8'h08,
  parameter int unsigned CTRL_OFS  = 8'h0C,
  parameter int unsigned OFS_RESET = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic [STAT_W-1:0] evt_i,
  output logic [1:0]        tx_level_o,
  output logic [2:0]        rx_level_o,
  output logic              break_o,
  output logic [4:0]        sample_ofs_o,
  output logic              cts_en_o,
  output logic              cts_inv_o,
  output logic [1:0]        rx_tmo_o,
  output logic              rts_en_o,
  output logic [1:0]        rts_level_o,
  output logic              rts_inv_o,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_OFS);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_OFS);

  logic              sel_stat, sel_ctrl;
  logic [STAT_W-1:0] status;
  ctrl_t             ctrl;
  logic              unused_wdata;

  assign sel_stat     = (bus_addr_i == A_STAT);
  assign sel_ctrl     = (bus_addr_i == A_CTRL);
  assign unused_wdata = ^bus_wdata_i[DATA_W-1:CTRL_W];

  uart_irq_status u_status (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (bus_wr_i && sel_stat),
    .wdata_i  (bus_wdata_i[STAT_W-1:0]),
    .evt_i    (evt_i),
    .status_o (status)
  );

  uart_irq_ctrl #(.OFS_RESET(OFS_RESET)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (bus_wr_i && sel_ctrl),
    .wdata_i (bus_wdata_i[CTRL_W-1:0]),
    .ctrl_o  (ctrl)
  );

  uart_irq_combine u_combine (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .status_i (status),
    .tx_ie_i  (ctrl.tx_ie),
    .rx_ie_i  (ctrl.rx_ie),
    .err_ie_i (ctrl.err_ie),
    .irq_o    (irq_o)
  );

  always_comb begin
    bus_rdata_o = '0;
    if (sel_stat)      bus_rdata_o[STAT_W-1:0] = status;
    else if (sel_ctrl) bus_rdata_o[CTRL_W-1:0] = ctrl;
  end

  assign tx_level_o   = ctrl.tx_thr;
  assign rx_level_o   = ctrl.rx_thr;
  assign break_o      = ctrl.brk;
  assign sample_ofs_o = ctrl.ofs;
  assign cts_en_o     = ctrl.cts_en;
  assign cts_inv_o    = ctrl.cts_inv;
  assign rx_tmo_o     = ctrl.tmo;
  assign rts_en_o     = ctrl.rts_en;
  assign rts_level_o  = ctrl.rts_lvl;
  assign rts_inv_o    = ctrl.rts_inv;

  assert_stat_iso_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(bus_wr_i && sel_stat) && evt_i == '0) |=> $stable(status));
  assert_rd_hi_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_stat |-> (bus_rdata_o[DATA_W-1:STAT_W] == '0));
endmodule

// File: tb/uart_irq_regs_tb.sv
module uart_irq_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [6:0]  evt = '0;
  logic [1:0]  tx_level, rx_tmo, rts_level;
  logic [2:0]  rx_level;
  logic [4:0]  sample_ofs;
  logic        brk, cts_en, cts_inv, rts_en, rts_inv, irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  uart_irq_regs u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_wr_i(wr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .evt_i(evt),
    .tx_level_o(tx_level), .rx_level_o(rx_level), .break_o(brk),
    .sample_ofs_o(sample_ofs), .cts_en_o(cts_en), .cts_inv_o(cts_inv),
    .rx_tmo_o(rx_tmo), .rts_en_o(rts_en), .rts_level_o(rts_level),
    .rts_inv_o(rts_inv), .irq_o(irq)
  );

  // {wr, addr[7:0], wdata[31:0], evt[6:0], exp_status[6:0], exp_irq}
  localparam int NV = 13;
  localparam logic [55:0] VEC [NV] = '{
    {1'b1, 8'h0C, 32'h0000_28E0, 7'h00, 7'h00, 1'b0}, // enable all groups
    {1'b0, 8'h00, 32'h0,         7'h01, 7'h01, 1'b1}, // R2 tx request
    {1'b1, 8'h08, 32'h0000_0001, 7'h00, 7'h00, 1'b0}, // R3 clear
    {1'b0, 8'h00, 32'h0,         7'h40, 7'h40, 1'b0}, // R7 bit6 no irq
    {1'b0, 8'h00, 32'h0,         7'h04, 7'h44, 1'b1}, // R2 rx timeout
    {1'b1, 8'h08, 32'h0000_0000, 7'h00, 7'h44, 1'b1}, // R3 zero keeps
    {1'b1, 8'h08, 32'h0000_0004, 7'h04, 7'h44, 1'b1}, // R4 set wins
    {1'b1, 8'h08, 32'hFFFF_FFFF, 7'h00, 7'h00, 1'b0}, // R3 clear all
    {1'b0, 8'h00, 32'h0,         7'h38, 7'h38, 1'b1}, // R7 error group
    {1'b1, 8'h0C, 32'h0000_2860, 7'h00, 7'h38, 1'b0}, // R7 err disabled
    {1'b1, 8'h08, 32'h0000_0008, 7'h02, 7'h32, 1'b1}, // R4 mixed bits
    {1'b1, 8'h10, 32'hFFFF_FFFF, 7'h00, 7'h32, 1'b1}, // R8 stray offset
    {1'b1, 8'h0C, 32'h0000_2800, 7'h00, 7'h32, 1'b0}  // R8 ctrl write
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; wr = 1'b1; wdata = d;
    @(negedge clk);
    wr = 1'b0; wdata = '0;
  endtask

  task automatic check_fields(string req, logic [21:0] c);
    #1;
    check(req, {30'd0, tx_level},   {30'd0, c[1:0]});
    check(req, {29'd0, rx_level},   {29'd0, c[4:2]});
    check(req, {31'd0, brk},        {31'd0, c[8]});
    check(req, {27'd0, sample_ofs}, {27'd0, c[13:9]});
    check(req, {30'd0, cts_inv, cts_en}, {30'd0, c[15:14]});
    check(req, {30'd0, rx_tmo},     {30'd0, c[17:16]});
    check(req, {31'd0, rts_en},     {31'd0, c[18]});
    check(req, {30'd0, rts_level},  {30'd0, c[20:19]});
    check(req, {31'd0, rts_inv},    {31'd0, c[21]});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    addr = 8'h08; #1;
    check("R1 status", rdata, 32'h0);
    check("R1 irq", {31'd0, irq}, 32'd0);
    addr = 8'h0C; #1;
    check("R1 ctrl", rdata, 32'h0000_2800);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      wr = VEC[i][55]; addr = VEC[i][54:47]; wdata = VEC[i][46:15];
      evt = VEC[i][14:8];
      @(negedge clk);
      wr = 1'b0; wdata = '0; evt = '0; addr = 8'h08;
      #1;
      check($sformatf("R2/R3/R4/R7/R8 vec%0d status", i), rdata, {25'd0, VEC[i][7:1]});
      check($sformatf("R7 vec%0d irq", i), {31'd0, irq}, {31'd0, VEC[i][0]});
    end

    // R5 / R6 control readback and field decode
    bus_write(8'h0C, 32'hFFFF_FFFF);
    addr = 8'h0C; #1;
    check("R5 ctrl all ones", rdata, 32'h003F_FFFF);
    check_fields("R6 all ones", 22'h3F_FFFF);
    bus_write(8'h0C, 32'h002A_AAAA);
    addr = 8'h0C; #1;
    check("R5 ctrl pattern", rdata, 32'h002A_AAAA);
    check_fields("R6 pattern A", 22'h2A_AAAA);
    bus_write(8'h0C, 32'h0015_5555);
    check_fields("R6 pattern 5", 22'h15_5555);
    // R8 status writes leave control untouched
    bus_write(8'h08, 32'hFFFF_FFFF);
    addr = 8'h0C; #1;
    check("R8 ctrl after status write", rdata, 32'h0015_5555);
    addr = 8'h04; #1;
    check("R8 other offset reads 0", rdata, 32'h0);

    // R9 upper status bits stay zero
    @(negedge clk);
    evt = 7'h7F;
    @(negedge clk);
    evt = '0; addr = 8'h08; #1;
    check("R9 status upper", rdata, 32'h0000_007F);
    // R7 tx enable alone, then rx enable alone
    bus_write(8'h0C, 32'h0000_0020);
    #1; check("R7 tx enable only", {31'd0, irq}, 32'd1);
    bus_write(8'h08, 32'h0000_0001);
    #1; check("R7 tx cleared", {31'd0, irq}, 32'd0);
    bus_write(8'h0C, 32'h0000_0040);
    #1; check("R7 rx enable only", {31'd0, irq}, 32'd1);
    bus_write(8'h08, 32'h0000_0006);
    #1; check("R7 rx cleared", {31'd0, irq}, 32'd0);
    addr = 8'h08; #1;
    check("R3 remaining bits", rdata, 32'h0000_0078);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule